// File: doc/BRIEF.md
# Write-Through Combining Store Buffer

This block is a small direct-mapped buffer that sits between a store source and a slower next-level cache. Every accepted store names a line address, a full line of data and a byte-enable mask. The low bits of the line address pick a buffer line. The remaining bits are kept as that line's tag. Each line records, byte by byte, which bytes still have to be written through. Bytes that were never written are not valid data, so a line never drains them. When several stores go to a line that is still waiting, they fold into one line and leave the buffer as a single masked write.

The drain side offers one line per transaction. Each transaction carries the line address, the line data and the mask of pending bytes. A line's pending mask is cleared only when the next level accepts the transfer. If a store arrives at a line whose bytes are still pending but with a different tag, the buffer holds that store back. It waits until the resident line has fully drained and then installs the store in its place. A flush request drains everything and reports completion with a one-cycle pulse.

Back-pressure rules:
- Store side: a store is taken on a cycle where `st_valid` and `st_ready` are both high. `st_ready` never depends on `st_valid` or on `wr_ready`.
- Drain side: a transfer happens on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_line_addr` stays fixed. `wr_mask` may only gain bits, and `wr_data` shows the latest merged bytes. The next level writes whatever it sees in the accepting cycle.

Top module: `wcb_top`

## Requirements
- R1: After reset, no line holds pending bytes. `wr_valid` and `flush_done` are low and `st_ready` is high.
- R2: The line index is the low log2(LINES) bits of `st_line_addr` and the tag is the remaining bits. A store to a line with no pending bytes is accepted in the cycle it is presented, whatever its tag. The line's pending mask then becomes the store's byte enables.
- R3: Byte b of a line is `data[8b+7:8b]` and is governed by mask bit b. A store to a line with pending bytes and the same tag is accepted at once. Its enabled bytes overwrite the line and its mask bits are ORed into the pending mask, so a single transfer carries the union of bytes with their latest values.
- R4: A store whose index holds pending bytes under a different tag sees `st_ready` low until that line has drained. The resident bytes reach the next level unchanged.
- R5: Once the conflicting line has drained, the held store is installed. The line's tag becomes the store's tag and its pending mask equals only that store's byte enables.
- R6: `wr_valid` is high only while some line has pending bytes. When no transfer is stalled, the pending line with the lowest index is offered. `wr_line_addr` is {tag, index} and `wr_mask` is that line's pending mask.
- R7: A line's pending mask is cleared only by an accepted transfer. Bytes stored into that line in the accepting cycle stay pending and are offered again.
- R8: While a transfer waits (`wr_valid` high, `wr_ready` low), the same line stays offered even if a lower index becomes pending. Its mask never loses bits.
- R9: After `flush` is sampled high, `st_ready` is low until completion. `flush_done` pulses for one cycle once no line has pending bytes. By then every byte of every accepted store has been handed to the next level.
- R10: Under any mix of stores and back-pressure, the next level ends up holding, for each byte ever stored, the value of the most recent store to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_line_addr | input | LADDR_W | Line address of the store |
| st_data | input | LINE_BYTES*8 | Store data, byte b in bits 8b+7:8b |
| st_be | input | LINE_BYTES | Byte enables of the store |
| wr_valid | output | 1 | A masked line write is offered |
| wr_ready | input | 1 | Next level accepts the offered write |
| wr_line_addr | output | LADDR_W | Line address of the offered write |
| wr_data | output | LINE_BYTES*8 | Line data of the offered write |
| wr_mask | output | LINE_BYTES | Bytes to be written by the next level |
| flush | input | 1 | Request to drain every pending line |
| flush_done | output | 1 | One-cycle pulse when a flush has completed |

## Verification
The bench builds the block with 4 lines of 4 bytes and a 6-bit line address, which gives a 4-bit tag. With that setting, random stores across only 64 line addresses run into tag conflicts on almost every index, and the drain-order, lock and same-cycle merge cases can be set up in a handful of directed stores. Random back-pressure on the drain side interleaves stalls, merges and installs. A byte-level model of the next level is then compared against the last value stored to each byte.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  // How an incoming store relates to the line it indexes
  typedef enum logic [1:0] {
    ST_INSTALL = 2'd0,  // line empty: take store, replace tag
    ST_MERGE   = 2'd1,  // same tag with pending bytes: fold in
    ST_STALL   = 2'd2   // other tag with pending bytes: hold back
  } st_kind_e;
endpackage

// File: rtl/wcb_line.sv
module wcb_line #(
  parameter int TAG_W = 4,
  parameter int NB    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              install,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [NB*8-1:0]   data_in,
  input  logic [NB-1:0]     be_in,
  input  logic              clr_en,
  output logic [TAG_W-1:0]  tag_q,
  output logic [NB*8-1:0]   data_q,
  output logic [NB-1:0]     mask_q
);
  logic [NB-1:0] mask_nxt;

  // An accepted drain removes the bytes it carried. A store in the
  // same cycle adds its own bytes back afterwards.
  always_comb begin
    mask_nxt = clr_en ? '0 : mask_q;
    if (wr_en) mask_nxt = mask_nxt | be_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (wr_en && install) tag_q <= tag_in;
      for (int b = 0; b < NB; b++) begin
        if (wr_en && be_in[b]) data_q[b*8 +: 8] <= data_in[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/wcb_pick.sv
module wcb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/wcb_top.sv
module wcb_top #(
  parameter int LINE_BYTES = 8,
  parameter int LINES      = 8,   // power of two, at least 2
  parameter int LADDR_W    = 26
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [LADDR_W-1:0]      st_line_addr,
  input  logic [LINE_BYTES*8-1:0] st_data,
  input  logic [LINE_BYTES-1:0]   st_be,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [LADDR_W-1:0]      wr_line_addr,
  output logic [LINE_BYTES*8-1:0] wr_data,
  output logic [LINE_BYTES-1:0]   wr_mask,
  input  logic                    flush,
  output logic                    flush_done
);
  import wcb_pkg::*;

  localparam int DATA_W = LINE_BYTES * 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = LADDR_W - IDX_W;

  logic [TAG_W-1:0]      tag_a  [LINES];
  logic [DATA_W-1:0]     data_a [LINES];
  logic [LINE_BYTES-1:0] mask_a [LINES];
  logic [LINES-1:0]      busy;

  logic [IDX_W-1:0] st_idx;
  logic [TAG_W-1:0] st_tag;
  st_kind_e         st_kind;
  logic             st_fire;

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             lock_q;
  logic [IDX_W-1:0] lock_idx_q;
  logic [IDX_W-1:0] drain_idx;
  logic             wr_fire;

  logic flush_pend_q;
  logic flush_hold;
  logic done_cond;

  assign st_idx = st_line_addr[IDX_W-1:0];
  assign st_tag = st_line_addr[LADDR_W-1:IDX_W];

  // Classify the store against the line it maps to
  always_comb begin
    if (!busy[st_idx])                 st_kind = ST_INSTALL;
    else if (tag_a[st_idx] == st_tag)  st_kind = ST_MERGE;
    else                               st_kind = ST_STALL;
  end

  assign flush_hold = flush | flush_pend_q;
  assign st_ready   = !flush_hold && (st_kind != ST_STALL);
  assign st_fire    = st_valid && st_ready;

  // Line storage, one slice per index
  for (genvar g = 0; g < LINES; g++) begin : g_line
    wcb_line #(.TAG_W(TAG_W), .NB(LINE_BYTES)) u_line (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (st_fire && (st_idx == IDX_W'(g))),
      .install (st_kind == ST_INSTALL),
      .tag_in  (st_tag),
      .data_in (st_data),
      .be_in   (st_be),
      .clr_en  (wr_fire && (drain_idx == IDX_W'(g))),
      .tag_q   (tag_a[g]),
      .data_q  (data_a[g]),
      .mask_q  (mask_a[g])
    );
    assign busy[g] = |mask_a[g];
  end

  wcb_pick #(.N(LINES), .IW(IDX_W)) u_pick (
    .req (busy),
    .any (pick_any),
    .idx (pick_idx)
  );

  // A stalled offer keeps its line until it is accepted
  assign drain_idx    = lock_q ? lock_idx_q : pick_idx;
  assign wr_valid     = pick_any;
  assign wr_fire      = wr_valid && wr_ready;
  assign wr_line_addr = {tag_a[drain_idx], drain_idx};
  assign wr_data      = data_a[drain_idx];
  assign wr_mask      = mask_a[drain_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= wr_valid && !wr_ready;
      lock_idx_q <= drain_idx;
    end
  end

  // Flush tracking
  assign done_cond = flush_pend_q && !pick_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_pend_q <= 1'b0;
      flush_done   <= 1'b0;
    end else begin
      flush_pend_q <= (flush_pend_q | flush) & ~done_cond;
      flush_done   <= done_cond;
    end
  end
endmodule

// File: rtl/wcb_chk.sv
module wcb_chk #(
  parameter int LINE_BYTES = 8,
  parameter int LADDR_W    = 26
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  st_ready,
  input logic                  wr_valid,
  input logic                  wr_ready,
  input logic [LADDR_W-1:0]    wr_line_addr,
  input logic [LINE_BYTES-1:0] wr_mask,
  input logic                  flush,
  input logic                  flush_done
);
  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_line_addr)));

  // R8
  mask_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (($past(wr_mask) & ~wr_mask) == '0));

  // R6
  offer_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_mask != '0));

  // R9
  flush_block_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !st_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flush_done |=> !flush_done);

  // R9
  done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> !wr_valid);
endmodule

bind wcb_top wcb_chk #(.LINE_BYTES(LINE_BYTES), .LADDR_W(LADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .st_ready     (st_ready),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_line_addr (wr_line_addr),
  .wr_mask      (wr_mask),
  .flush        (flush),
  .flush_done   (flush_done)
);

// File: tb/wcb_top_test.sv
module wcb_top_test;
  localparam int LB  = 4;
  localparam int NL  = 4;
  localparam int LA  = 6;
  localparam int DW  = LB * 8;
  localparam int NBY = (1 << LA) * LB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          st_valid;
  logic          st_ready;
  logic [LA-1:0] st_line_addr;
  logic [DW-1:0] st_data;
  logic [LB-1:0] st_be;
  logic          wr_valid;
  logic          wr_ready;
  logic [LA-1:0] wr_line_addr;
  logic [DW-1:0] wr_data;
  logic [LB-1:0] wr_mask;
  logic          flush;
  logic          flush_done;

  wcb_top #(.LINE_BYTES(LB), .LINES(NL), .LADDR_W(LA)) uut (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_ready(st_ready), .st_line_addr(st_line_addr),
    .st_data(st_data), .st_be(st_be),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line_addr(wr_line_addr),
    .wr_data(wr_data), .wr_mask(wr_mask),
    .flush(flush), .flush_done(flush_done)
  );

  logic [7:0]    mem     [NBY];
  logic [7:0]    ref_mem [NBY];
  logic          written [NBY];
  logic [LA-1:0] log_addr [512];
  logic [LB-1:0] log_mask [512];
  logic [DW-1:0] log_data [512];
  int log_n;
  int rdy_mode;
  int n_chk;
  int n_bad;
  bit done_flag;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Next-level model: drives ready, records accepted writes
  initial begin
    wr_ready = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      case (rdy_mode)
        0:       wr_ready = 1'b0;
        1:       wr_ready = 1'b1;
        default: wr_ready = ($urandom % 3) != 0;
      endcase
      #1;
      if (!rst && wr_valid && wr_ready) begin
        for (int b = 0; b < LB; b++)
          if (wr_mask[b]) mem[int'(wr_line_addr) * LB + b] = wr_data[b*8 +: 8];
        if (log_n < 512) begin
          log_addr[log_n] = wr_line_addr;
          log_mask[log_n] = wr_mask;
          log_data[log_n] = wr_data;
        end
        log_n++;
      end
    end
  end

  // Present a store and hold it until taken; report stall cycles
  task automatic store(input logic [LA-1:0] la, input logic [DW-1:0] d,
                       input logic [LB-1:0] be, output int waits);
    waits = 0;
    @(negedge clk);
    st_valid = 1'b1; st_line_addr = la; st_data = d; st_be = be;
    #1;
    while (!st_ready && waits < 2000) begin
      @(negedge clk); #1;
      waits++;
    end
    @(posedge clk);
    for (int b = 0; b < LB; b++)
      if (be[b]) begin
        ref_mem[int'(la) * LB + b] = d[b*8 +: 8];
        written[int'(la) * LB + b] = 1'b1;
      end
    #1 st_valid = 1'b0;
  endtask

  task automatic drain_all();
    rdy_mode = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #4;
      if (!wr_valid) break;
    end
  endtask

  task automatic do_flush(input string tag);
    int k;
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk); #1;
    chk({tag, " st_ready low during flush"}, 64'(st_ready), 64'd0);
    k = 0;
    while (!flush_done && k < 5000) begin
      @(negedge clk); #1;
      k++;
    end
    chk({tag, " flush_done seen"}, 64'(flush_done), 64'd1);
    chk({tag, " nothing pending at done"}, 64'(wr_valid), 64'd0);
    @(negedge clk); #1;
    chk({tag, " flush_done one cycle"}, 64'(flush_done), 64'd0);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int w;
    void'($urandom(32'd2024));
    for (int i = 0; i < NBY; i++) written[i] = 1'b0;
    n_chk = 0; n_bad = 0; log_n = 0; rdy_mode = 0; done_flag = 1'b0;
    rst = 1'b1; st_valid = 1'b0; st_line_addr = '0; st_data = '0; st_be = '0;
    flush = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #4;
    chk("R1 wr_valid after reset", 64'(wr_valid), 64'd0);
    chk("R1 st_ready after reset", 64'(st_ready), 64'd1);
    chk("R1 flush_done after reset", 64'(flush_done), 64'd0);

    // R2: install into an empty line (index 1, tag 2)
    store(6'h09, 32'h11223344, 4'b0011, w);
    chk("R2 install without stall", 64'(w), 64'd0);
    @(negedge clk); #4;
    chk("R2 offered", 64'(wr_valid), 64'd1);
    chk("R2 address", 64'(wr_line_addr), 64'h09);
    chk("R2 mask", 64'(wr_mask), 64'b0011);

    // R3: merge into the pending line
    store(6'h09, 32'hAABBCCDD, 4'b0110, w);
    chk("R3 merge without stall", 64'(w), 64'd0);
    @(negedge clk); #4;
    chk("R3 union mask", 64'(wr_mask), 64'b0111);
    chk("R3 merged bytes", 64'(wr_data[23:0]), 64'hBBCC44);

    // R8 / R6: lower index becomes pending while offer is stalled
    store(6'h02, 32'h01020304, 4'b1111, w);
    store(6'h04, 32'h00000055, 4'b0001, w);
    @(negedge clk); #4;
    chk("R8 stalled offer keeps address", 64'(wr_line_addr), 64'h09);
    log_n = 0;
    drain_all();
    chk("R6 transfer count", 64'(log_n), 64'd3);
    chk("R8 first transfer is stalled line", 64'(log_addr[0]), 64'h09);
    chk("R3 single transfer mask", 64'(log_mask[0]), 64'b0111);
    chk("R6 lowest index next", 64'(log_addr[1]), 64'h04);
    chk("R6 then index 2", 64'(log_addr[2]), 64'h02);

    // R4 / R5: conflicting tag on index 1
    rdy_mode = 0;
    store(6'h05, 32'hA1A2A3A4, 4'b1111, w);
    @(negedge clk);
    st_valid = 1'b1; st_line_addr = 6'h0D; st_data = 32'hB1B2B3B4; st_be = 4'b0010;
    #1;
    chk("R4 conflict stalls", 64'(st_ready), 64'd0);
    repeat (3) @(negedge clk);
    #4;
    chk("R4 still stalled", 64'(st_ready), 64'd0);
    chk("R4 resident address", 64'(wr_line_addr), 64'h05);
    chk("R4 resident data intact", 64'(wr_data), 64'hA1A2A3A4);
    log_n = 0;
    rdy_mode = 1;
    store(6'h0D, 32'hB1B2B3B4, 4'b0010, w);
    rdy_mode = 0;
    chk("R4 old line drained first", 64'(log_addr[0]), 64'h05);
    chk("R4 old bytes unchanged", 64'(log_data[0]), 64'hA1A2A3A4);
    @(negedge clk); #4;
    chk("R5 new line address", 64'(wr_line_addr), 64'h0D);
    chk("R5 mask only new store", 64'(wr_mask), 64'b0010);
    chk("R5 new byte", 64'(wr_data[15:8]), 64'hB3);
    drain_all();

    // R2: any tag installs into an empty line
    rdy_mode = 0;
    store(6'h3D, 32'h99000000, 4'b1000, w);
    chk("R2 other tag installs at once", 64'(w), 64'd0);

    // R7: store in the same cycle the line is accepted
    log_n = 0;
    @(negedge clk);
    rdy_mode = 1;
    st_valid = 1'b1; st_line_addr = 6'h3D; st_data = 32'h00000077; st_be = 4'b0001;
    #1;
    chk("R7 merge ready", 64'(st_ready), 64'd1);
    @(posedge clk);
    ref_mem[8'h3D * LB] = 8'h77; written[8'h3D * LB] = 1'b1;
    ref_mem[8'h3D * LB + 3] = 8'h99; written[8'h3D * LB + 3] = 1'b1;
    #1 st_valid = 1'b0;
    rdy_mode = 0;
    @(negedge clk); #4;
    chk("R7 one transfer", 64'(log_n), 64'd1);
    chk("R7 transferred mask", 64'(log_mask[0]), 64'b1000);
    chk("R7 new byte still pending", 64'(wr_valid), 64'd1);
    chk("R7 pending mask", 64'(wr_mask), 64'b0001);

    // R9: flush with a pending line
    store(6'h10, 32'hCAFEF00D, 4'b1111, w);
    rdy_mode = 1;
    do_flush("R9");
    chk("R9 flushed data", 64'({mem[64], mem[65], mem[66], mem[67]}), 64'h0DF0FECA);

    // R10: random stores with random back-pressure
    rdy_mode = 2;
    for (int i = 0; i < 400; i++) begin
      logic [LB-1:0] be;
      be = LB'($urandom);
      if (be == '0) be = 4'b0100;
      store(LA'($urandom), $urandom, be, w);
    end
    do_flush("R10");
    for (int i = 0; i < NBY; i++)
      if (written[i]) chk($sformatf("R10 byte %0d", i), 64'(mem[i]), 64'(ref_mem[i]));

    summary();
  end
endmodule